// File: doc/BRIEF.md
# Reconfigurable bus mesh fabric

An N by N grid of nodes overlaid with a shared broadcast bus that is cut into pieces by local switches. Every node owns four bus ports (north, east, south, west). Each resolution step, every node presents a 4-bit switch code that partitions its four ports into groups joined inside the node. A port facing a neighbour is wired to that neighbour's opposite port. The connected pieces that result are the subbuses. Their shapes are arbitrary: chains, loops, crosses or single ports.

Each node may place one write on one of its ports. The write carries a single bit for the OR channel and, optionally, a word for the exclusive channel. After a pulse on `start`, the fabric samples all switch codes and writes. It floods values across the subbuses for a fixed number of cycles and then raises `valid`. From that point every port shows three things for its subbus: the OR of all written bits, the word written onto it, and a flag that reports disagreeing word writers. A higher-level sequencer can use the fabric for long-distance broadcasts, wired-OR voting, or plain neighbour shifts by choosing the switch codes.

Top module: `meshbus_fabric`

## Requirements
- R1: Switch code encoding, with ports named N, E, S, W and joined ports written together:
  - 0 = all isolated
  - 1 = NE, 2 = NS, 3 = NW, 4 = ES, 5 = EW, 6 = SW
  - 7 = NE+SW, 8 = NS+EW, 9 = NW+ES
  - 10 = NES, 11 = NEW, 12 = NSW, 13 = ESW
  - 14 = all four joined
  - Ports not named in a code are isolated.
- R2: Code 15 behaves exactly like code 0.
- R3: A node's N port is wired to the S port of the node above it, and its E port to the W port of the node to its right. A subbus is the maximal set of ports connected through these links and the in-node joins. Every port of one subbus reads identical OR and conflict results.
- R4: After resolution, every port reads the logical OR of all bits written onto its subbus.
- R5: When exactly one word is written onto a subbus, or several identical words, every port of that subbus reads that word. A subbus with no word writer reads zero.
- R6: When two word writers on one subbus present different words, every port of that subbus reads its conflict flag as 1; otherwise the flag is 0.
- R7: A port on the grid's outer edge has no partner. It joins nothing outside its node and adds nothing beyond its own node's write.
- R8: `valid` falls at the clock edge that samples `start`. It rises exactly 2*N*N+2 edges later and then holds until the next `start`.
- R9: Switch codes and writes are sampled only at the `start` edge. Changes on those inputs while resolving, or while `valid` is high, do not alter the results.
- R10: After reset, `valid` and every read output are 0.
- R11: Node k = row*N + col, with row 0 on top and col 0 on the left. `drvPort` field k selects the port written (0 = N, 1 = E, 2 = S, 3 = W). Read outputs are indexed by k*4 + port.
- R12: With all switches isolated, a word written on a node's E port is read at the W port of its right-hand neighbour. Plain neighbour shifts are formed this way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Samples configuration and writes, begins resolution |
| swCode | input | N*N*4 | Switch code per node, field k at [k*4+:4] |
| drvPort | input | N*N*2 | Port each node writes onto |
| bitVal | input | N*N | Bit each node writes onto the OR channel |
| wordEn | input | N*N | Node places a word on the exclusive channel |
| wordVal | input | N*N*W | Word per node, field k at [k*W+:W] |
| valid | output | 1 | Results are resolved |
| rdBit | output | N*N*4 | OR result per port |
| rdWord | output | N*N*4*W | Word result per port |
| rdConflict | output | N*N*4 | Disagreeing word writers per port |

## Verification
The bench builds the fabric with N=3 and W=4. That gives 36 port segments, a latency of 20 cycles, and an interior node together with corner and side nodes, so every kind of edge port occurs. At this size, all 16 switch codes can be swept uniformly over the grid, and many random mixed configurations can be compared against a connectivity model built from pair lists. Words are drawn from a small set, so both identical and disagreeing writers on one subbus occur often.

// File: rtl/meshbus_pkg.sv
package meshbus_pkg;

  localparam int PORTS = 4;

  typedef struct packed {
    logic load;
    logic step;
  } meshStrobeT;

  // Group label per port {W,S,E,N}: ports with equal labels are joined.
  function automatic logic [7:0] portGroups(input logic [3:0] code);
    logic [7:0] g;
    case (code)
      4'd1:    g = {2'd3, 2'd2, 2'd0, 2'd0};
      4'd2:    g = {2'd3, 2'd0, 2'd1, 2'd0};
      4'd3:    g = {2'd0, 2'd2, 2'd1, 2'd0};
      4'd4:    g = {2'd3, 2'd1, 2'd1, 2'd0};
      4'd5:    g = {2'd1, 2'd2, 2'd1, 2'd0};
      4'd6:    g = {2'd2, 2'd2, 2'd1, 2'd0};
      4'd7:    g = {2'd2, 2'd2, 2'd0, 2'd0};
      4'd8:    g = {2'd1, 2'd0, 2'd1, 2'd0};
      4'd9:    g = {2'd0, 2'd1, 2'd1, 2'd0};
      4'd10:   g = {2'd3, 2'd0, 2'd0, 2'd0};
      4'd11:   g = {2'd0, 2'd2, 2'd0, 2'd0};
      4'd12:   g = {2'd0, 2'd0, 2'd1, 2'd0};
      4'd13:   g = {2'd1, 2'd1, 2'd1, 2'd0};
      4'd14:   g = {2'd0, 2'd0, 2'd0, 2'd0};
      default: g = {2'd3, 2'd2, 2'd1, 2'd0};
    endcase
    return g;
  endfunction

  function automatic logic portsJoined(input logic [3:0] code, input int p, input int q);
    logic [7:0] g;
    g = portGroups(code);
    return g[p*2 +: 2] == g[q*2 +: 2];
  endfunction

endpackage

// File: rtl/meshbus_ctrl.sv
module meshbus_ctrl
  import meshbus_pkg::*;
#(
  parameter int ITER = 34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output meshStrobeT strobe,
  output logic       valid
);

  localparam int CW = $clog2(ITER + 1);

  logic          running;
  logic [CW-1:0] cnt;

  always_comb begin
    strobe.load = start;
    strobe.step = running && !start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      valid   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      valid   <= 1'b0;
    end else if (running) begin
      if (cnt == CW'(ITER - 1)) begin
        running <= 1'b0;
        valid   <= 1'b1;
      end
      cnt <= cnt + 1'b1;
    end
  end

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> !running);                                            // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !valid);                                              // R8
  AST_LAST_STEP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (running && !start && cnt == CW'(ITER - 1)) |=> valid);         // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < CW'(ITER)));                                 // R8

endmodule

// File: rtl/meshbus_node.sv
module meshbus_node
  import meshbus_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = W + 3
) (
  input  logic [3:0]        swCode,
  input  logic [4*SW-1:0]   ownSeg,
  input  logic [4*SW-1:0]   nbrSeg,
  output logic [4*SW-1:0]   nextSeg
);

  typedef struct packed {
    logic         conf;
    logic         has;
    logic         orBit;
    logic [W-1:0] word;
  } segT;

  function automatic segT mergeSeg(input segT a, input segT b);
    segT m;
    m.orBit = a.orBit | b.orBit;
    m.has   = a.has | b.has;
    m.conf  = a.conf | b.conf | (a.has && b.has && (a.word != b.word));
    m.word  = a.has ? a.word : b.word;
    return m;
  endfunction

  segT extSeg [PORTS];
  segT accSeg [PORTS];

  always_comb begin
    for (int q = 0; q < PORTS; q++) begin
      extSeg[q] = mergeSeg(ownSeg[q*SW +: SW], nbrSeg[q*SW +: SW]);
    end
    for (int p = 0; p < PORTS; p++) begin
      accSeg[p] = '0;
      for (int q = 0; q < PORTS; q++) begin
        if (portsJoined(swCode, p, q)) accSeg[p] = mergeSeg(accSeg[p], extSeg[q]);
      end
      nextSeg[p*SW +: SW] = accSeg[p];
    end
  end

endmodule

// File: rtl/meshbus_datapath.sv
module meshbus_datapath
  import meshbus_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  meshStrobeT         strobe,
  input  logic               valid,
  input  logic [N*N*4-1:0]   swCode,
  input  logic [N*N*2-1:0]   drvPort,
  input  logic [N*N-1:0]     bitVal,
  input  logic [N*N-1:0]     wordEn,
  input  logic [N*N*W-1:0]   wordVal,
  output logic [N*N*4-1:0]   rdBit,
  output logic [N*N*4*W-1:0] rdWord,
  output logic [N*N*4-1:0]   rdConflict
);

  localparam int NN   = N * N;
  localparam int SW   = W + 3;
  localparam int NSEG = NN * PORTS;
  localparam int BPOS = W;
  localparam int HPOS = W + 1;
  localparam int CPOS = W + 2;

  logic [NSEG*SW-1:0] segQ;
  logic [NSEG*SW-1:0] seedVec;
  logic [NSEG*SW-1:0] nextVec;
  logic [NSEG*SW-1:0] nbrVec;
  logic [NN*4-1:0]    codeQ;

  always_comb begin
    for (int k = 0; k < NN; k++) begin
      for (int p = 0; p < PORTS; p++) begin
        logic sel;
        sel = (drvPort[k*2 +: 2] == 2'(p));
        seedVec[(k*PORTS+p)*SW +: SW] = {1'b0, wordEn[k] && sel, bitVal[k] && sel,
                                         (wordEn[k] && sel) ? wordVal[k*W +: W] : {W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segQ  <= '0;
      codeQ <= '0;
    end else if (strobe.load) begin
      segQ  <= seedVec;
      codeQ <= swCode;
    end else if (strobe.step) begin
      segQ  <= nextVec;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int K = r * N + c;

      if (r > 0) begin : g_nbrN
        assign nbrVec[(K*4+0)*SW +: SW] = segQ[((K-N)*4+2)*SW +: SW];
      end else begin : g_edgeN
        assign nbrVec[(K*4+0)*SW +: SW] = '0;
      end
      if (c < N-1) begin : g_nbrE
        assign nbrVec[(K*4+1)*SW +: SW] = segQ[((K+1)*4+3)*SW +: SW];
      end else begin : g_edgeE
        assign nbrVec[(K*4+1)*SW +: SW] = '0;
      end
      if (r < N-1) begin : g_nbrS
        assign nbrVec[(K*4+2)*SW +: SW] = segQ[((K+N)*4+0)*SW +: SW];
      end else begin : g_edgeS
        assign nbrVec[(K*4+2)*SW +: SW] = '0;
      end
      if (c > 0) begin : g_nbrW
        assign nbrVec[(K*4+3)*SW +: SW] = segQ[((K-1)*4+1)*SW +: SW];
      end else begin : g_edgeW
        assign nbrVec[(K*4+3)*SW +: SW] = '0;
      end

      meshbus_node #(.W(W), .SW(SW)) u_node (
        .swCode (codeQ[K*4 +: 4]),
        .ownSeg (segQ[K*4*SW +: 4*SW]),
        .nbrSeg (nbrVec[K*4*SW +: 4*SW]),
        .nextSeg(nextVec[K*4*SW +: 4*SW])
      );

      if (r > 0) begin : g_chkNS
        AST_LINK_NS: assert property (@(posedge clk) disable iff (!rstN)
          valid |-> (segQ[(K*4+0)*SW+BPOS +: 3] == segQ[((K-N)*4+2)*SW+BPOS +: 3])); // R3
      end
      if (c > 0) begin : g_chkEW
        AST_LINK_EW: assert property (@(posedge clk) disable iff (!rstN)
          valid |-> (segQ[(K*4+3)*SW+BPOS +: 3] == segQ[((K-1)*4+1)*SW+BPOS +: 3])); // R3
      end
      AST_FULL_JOIN: assert property (@(posedge clk) disable iff (!rstN)
        (valid && codeQ[K*4 +: 4] == 4'd14) |->
        (rdBit[K*4 +: 4] == 4'hF || rdBit[K*4 +: 4] == 4'h0));            // R1
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_out
    assign rdBit[i]          = segQ[i*SW + BPOS];
    assign rdConflict[i]     = segQ[i*SW + CPOS];
    assign rdWord[i*W +: W]  = segQ[i*SW +: W];

    AST_CONF_HAS_WRITER: assert property (@(posedge clk) disable iff (!rstN)
      rdConflict[i] |-> segQ[i*SW + HPOS]);                               // R6
    AST_CONF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && rdConflict[i]) |=> rdConflict[i]);                  // R6
  end

endmodule

// File: rtl/meshbus_fabric.sv
module meshbus_fabric
  import meshbus_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [N*N*4-1:0]   swCode,
  input  logic [N*N*2-1:0]   drvPort,
  input  logic [N*N-1:0]     bitVal,
  input  logic [N*N-1:0]     wordEn,
  input  logic [N*N*W-1:0]   wordVal,
  output logic               valid,
  output logic [N*N*4-1:0]   rdBit,
  output logic [N*N*4*W-1:0] rdWord,
  output logic [N*N*4-1:0]   rdConflict
);

  localparam int ITER = 2 * N * N + 2;

  meshStrobeT strobe;

  meshbus_ctrl #(.ITER(ITER)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .valid (valid)
  );

  meshbus_datapath #(.N(N), .W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .valid     (valid),
    .swCode    (swCode),
    .drvPort   (drvPort),
    .bitVal    (bitVal),
    .wordEn    (wordEn),
    .wordVal   (wordVal),
    .rdBit     (rdBit),
    .rdWord    (rdWord),
    .rdConflict(rdConflict)
  );

endmodule

// File: tb/meshbus_fabric_test.sv
`timescale 1ns/1ps
module meshbus_fabric_test;

  localparam int N    = 3;
  localparam int W    = 4;
  localparam int NN   = N * N;
  localparam int NSEG = NN * 4;
  localparam int ITER = 2 * N * N + 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [NN*4-1:0]    swCode = '0;
  logic [NN*2-1:0]    drvPort = '0;
  logic [NN-1:0]      bitVal = '0;
  logic [NN-1:0]      wordEn = '0;
  logic [NN*W-1:0]    wordVal = '0;
  logic               valid;
  logic [NSEG-1:0]    rdBit;
  logic [NSEG*W-1:0]  rdWord;
  logic [NSEG-1:0]    rdConflict;

  meshbus_fabric #(.N(N), .W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .swCode(swCode), .drvPort(drvPort),
    .bitVal(bitVal), .wordEn(wordEn), .wordVal(wordVal), .valid(valid),
    .rdBit(rdBit), .rdWord(rdWord), .rdConflict(rdConflict)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0]   sCode [NN];
  logic [1:0]   sDrv  [NN];
  logic         sBit  [NN];
  logic         sEn   [NN];
  logic [W-1:0] sWord [NN];
  logic         eBit  [NSEG];
  logic         eConf [NSEG];
  logic [W-1:0] eWord [NSEG];
  int           lab   [NSEG];
  int pa [6] = '{0, 0, 0, 1, 1, 2};
  int pb [6] = '{1, 2, 3, 2, 3, 3};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Joined port pairs per code, bits: NE NS NW ES EW SW (R1, R2)
  function automatic logic [5:0] pairMask(input logic [3:0] code);
    case (code)
      4'd1:  return 6'b000001;
      4'd2:  return 6'b000010;
      4'd3:  return 6'b000100;
      4'd4:  return 6'b001000;
      4'd5:  return 6'b010000;
      4'd6:  return 6'b100000;
      4'd7:  return 6'b100001;
      4'd8:  return 6'b010010;
      4'd9:  return 6'b001100;
      4'd10: return 6'b001011;
      4'd11: return 6'b010101;
      4'd12: return 6'b100110;
      4'd13: return 6'b111000;
      4'd14: return 6'b111111;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic tie(input int a, input int b, inout bit changed);
    if (lab[a] != lab[b]) begin
      if (lab[a] < lab[b]) lab[b] = lab[a]; else lab[a] = lab[b];
      changed = 1'b1;
    end
  endtask

  task automatic computeExpected();
    bit changed;
    for (int i = 0; i < NSEG; i++) lab[i] = i;
    changed = 1'b1;
    while (changed) begin
      changed = 1'b0;
      for (int k = 0; k < NN; k++) begin
        logic [5:0] m;
        m = pairMask(sCode[k]);
        for (int x = 0; x < 6; x++) if (m[x]) tie(k*4 + pa[x], k*4 + pb[x], changed);
        if (k % N < N-1) tie(k*4 + 1, (k+1)*4 + 3, changed);
        if (k / N < N-1) tie(k*4 + 2, (k+N)*4 + 0, changed);
      end
    end
    for (int i = 0; i < NSEG; i++) begin
      bit seen;
      seen = 1'b0; eBit[i] = 1'b0; eConf[i] = 1'b0; eWord[i] = '0;
      for (int j = 0; j < NSEG; j++) begin
        if (lab[j] == lab[i] && int'(sDrv[j/4]) == j % 4) begin
          if (sBit[j/4]) eBit[i] = 1'b1;
          if (sEn[j/4]) begin
            if (seen && sWord[j/4] != eWord[i]) eConf[i] = 1'b1;
            if (!seen) begin eWord[i] = sWord[j/4]; seen = 1'b1; end
          end
        end
      end
    end
  endtask

  task automatic driveSaved();
    for (int k = 0; k < NN; k++) begin
      swCode[k*4 +: 4]  = sCode[k];
      drvPort[k*2 +: 2] = sDrv[k];
      bitVal[k]         = sBit[k];
      wordEn[k]         = sEn[k];
      wordVal[k*W +: W] = sWord[k];
    end
  endtask

  task automatic scramble();
    swCode  = (NN*4)'({$urandom, $urandom});
    drvPort = (NN*2)'($urandom);
    bitVal  = NN'($urandom);
    wordEn  = NN'($urandom);
    wordVal = (NN*W)'({$urandom, $urandom});
  endtask

  task automatic clearSaved(input logic [3:0] code);
    for (int k = 0; k < NN; k++) begin
      sCode[k] = code; sDrv[k] = 2'd0; sBit[k] = 1'b0; sEn[k] = 1'b0; sWord[k] = '0;
    end
  endtask

  task automatic randomSaved(input bit randCode, input logic [3:0] code);
    for (int k = 0; k < NN; k++) begin
      sCode[k] = randCode ? 4'($urandom % 16) : code;
      sDrv[k]  = 2'($urandom % 4);
      sBit[k]  = ($urandom % 4) == 0;
      sEn[k]   = ($urandom % 3) == 0;
      sWord[k] = W'($urandom % 4);
    end
  endtask

  task automatic runCase(input string tag, input bit scram);
    int lat;
    @(negedge clk);
    driveSaved();
    start = 1'b1;
    computeExpected();
    @(negedge clk);
    start = 1'b0;
    check(valid == 1'b0, {tag, " R8 valid low after start"}, valid, 0);
    lat = 0;
    while (!valid && lat < 100) begin
      @(negedge clk);
      lat++;
      if (scram) scramble();
    end
    check(lat == ITER, {tag, " R8 latency"}, lat, ITER);
    for (int i = 0; i < NSEG; i++) begin
      check(rdBit[i] == eBit[i], $sformatf("%s R4 bit seg %0d", tag, i), rdBit[i], eBit[i]);
      check(rdConflict[i] == eConf[i], $sformatf("%s R6 conflict seg %0d", tag, i),
            rdConflict[i], eConf[i]);
      if (!eConf[i])
        check(rdWord[i*W +: W] == eWord[i], $sformatf("%s R5 word seg %0d", tag, i),
              rdWord[i*W +: W], eWord[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(valid == 1'b0, "R10 valid", valid, 0);
    check(rdBit == '0, "R10 rdBit", rdBit, 0);
    check(rdConflict == '0, "R10 rdConflict", rdConflict, 0);
    check(rdWord == '0, "R10 rdWord", rdWord, 0);

    // R12: isolated switches give a neighbour transfer eastwards
    clearSaved(4'd0);
    sDrv[0] = 2'd1; sBit[0] = 1'b1; sEn[0] = 1'b1; sWord[0] = 4'd5;
    runCase("R12", 1'b0);
    check(rdWord[(1*4+3)*W +: W] == 4'd5, "R12 east neighbour W port word", rdWord[(1*4+3)*W +: W], 5);
    check(rdBit[1*4+3] == 1'b1, "R12 east neighbour W port bit", rdBit[1*4+3], 1);
    check(rdWord[(1*4+0)*W +: W] == 4'd0, "R12 other port untouched", rdWord[(1*4+0)*W +: W], 0);

    // R7 R11: corner node writes on its outer N port
    clearSaved(4'd14);
    sCode[0] = 4'd0; sDrv[0] = 2'd0; sBit[0] = 1'b1; sEn[0] = 1'b1; sWord[0] = 4'd9;
    runCase("R7 R11", 1'b0);
    check(rdBit == NSEG'(1), "R7 only edge port set", rdBit, 1);
    check(rdWord[0 +: W] == 4'd9, "R7 edge port word", rdWord[0 +: W], 9);

    // R2: code 15 acts as isolated
    randomSaved(1'b0, 4'd15);
    runCase("R2", 1'b0);

    // R1 R3: everything joined, one writer reaches every port
    clearSaved(4'd14);
    sDrv[4] = 2'd2; sEn[4] = 1'b1; sWord[4] = 4'd11; sBit[8] = 1'b1;
    runCase("R1 R3", 1'b0);
    check(rdConflict == '0, "R3 no conflict full mesh", rdConflict, 0);

    // R6: identical and differing words on one subbus
    clearSaved(4'd14);
    sEn[0] = 1'b1; sWord[0] = 4'd6; sEn[8] = 1'b1; sWord[8] = 4'd6; sDrv[8] = 2'd1;
    runCase("R6 same", 1'b0);
    sWord[8] = 4'd7;
    runCase("R6 differ", 1'b0);
    check(rdConflict == '1, "R6 conflict everywhere", rdConflict, -1);

    // R1 R11: uniform sweep of every code with staggered write ports
    for (int cd = 0; cd < 16; cd++) begin
      for (int k = 0; k < NN; k++) begin
        sCode[k] = 4'(cd); sDrv[k] = 2'(k % 4); sBit[k] = (k % 3) == 0;
        sEn[k] = (k % 2) == 0; sWord[k] = W'(k % 3);
      end
      runCase($sformatf("R1 R11 code %0d", cd), 1'b0);
    end

    // R3 R9: random mixed configurations, inputs scrambled while resolving
    for (int t = 0; t < 150; t++) begin
      randomSaved(1'b1, 4'd0);
      runCase("R3 R9", 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule